// File: doc/BRIEF.md
# Reconfigurable Interleaved Series-Capacitor PWM

This block drives the switches of several series-capacitor buck cells that share one load. Every cell has two switches. Both switches take their on-time from the same duty command, and the second switch runs half a switching period behind the first. The cells are spread evenly in phase so that their ripple currents partly cancel.

A fault diagnosis stage outside this block can flag a cell as failed. When that happens, the block holds both gates of the failed cell low. It then spreads the remaining healthy cells evenly over the period again, so interleaving stays as even as the surviving cell count allows.

A period counter sets the timing. It runs free and wraps once per switching period, and an external strobe can restart it. The block changes its working plan only at a period boundary. The plan is the duty values, the failed-cell mask and the phase offsets.

Top module: `sc_interleave_pwm`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, every gate output is low and the period counter is zero.
- R2: The period counter advances by one each clock and wraps from PERIOD-1 to 0. A high `sync_i` forces it to 0 at the next edge whatever its value. A boundary is a cycle in which `sync_i` is high or the counter holds PERIOD-1.
- R3: Duty commands and fault flags are captured only in a boundary cycle. Changes to them at any other time have no effect on the gates before the next boundary.
- R4: A captured duty value is limited to PERIOD/2-1. A larger command behaves exactly like PERIOD/2-1.
- R5: Let c be the counter value and off the cell's offset. Gate bit 2j (first switch of cell j) goes high one cycle after a counter value for which (c-off) mod PERIOD < duty. Gate bit 2j+1 (second switch) uses (c-off-PERIOD/2) mod PERIOD in the same way.
- R6: Healthy cells are ranked 0,1,2,... in ascending index order. With M healthy cells, rank r gets the offset r*floor(PERIOD/(2*M)).
- R7: A cell whose fault bit is 1 (bit j of `fault_i` for cell j) holds both of its gates low. This includes the case where every cell has failed.
- R8: The two gates of one cell are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_i | input | 1 | Period restart strobe |
| duty_i | input | N_CELLS*CNT_W | Duty command per cell, cell j in bits [j*CNT_W +: CNT_W] |
| fault_i | input | N_CELLS | Failed-cell flags, 1 = failed |
| gate_o | output | 2*N_CELLS | Gate drives, bit 2j first switch and bit 2j+1 second switch of cell j |

## Verification
Two events can land in the same cycle. One is capturing a new fault mask and duty set. The other is the counter's own wrap or an early restart strobe. The bench provokes this by changing the fault mask in the exact boundary cycle and by raising the strobe while the counter sits at PERIOD-1. A fault or duty change one cycle before and one cycle after a boundary shows whether it is taken early, on time or late. A reference model predicts every gate bit in every cycle, and the result is judged against it, including the new ranking after the master cell fails.

// File: rtl/sc_pwm_pkg.sv
package sc_pwm_pkg;

    // Phase of a counter value relative to an offset, modulo the period.
    function automatic int unsigned phase_of(int unsigned cnt, int unsigned off,
                                             int unsigned period);
        return (cnt >= off) ? (cnt - off) : (cnt + period - off);
    endfunction

    // Move a phase by half a period.
    function automatic int unsigned shift_half(int unsigned ph, int unsigned period);
        int unsigned h;
        h = period / 2;
        return (ph >= h) ? (ph - h) : (ph + h);
    endfunction

    // Carrier spacing for m healthy cells. The loop bound is a constant,
    // so each division has a constant divisor.
    function automatic int unsigned spacing(int unsigned period, int unsigned n_max,
                                            int unsigned m);
        int unsigned s;
        s = 0;
        for (int unsigned k = 1; k <= n_max; k++) begin
            if (k == m) s = period / (2 * k);
        end
        return s;
    endfunction

endpackage

// File: rtl/sc_pwm_plan.sv
module sc_pwm_plan #(
    parameter int N_CELLS = 4,
    parameter int PERIOD  = 5000,
    parameter int CNT_W   = 13
) (
    input  logic [N_CELLS-1:0]            fault_i,
    output logic [N_CELLS-1:0][CNT_W-1:0] off_o
);
    import sc_pwm_pkg::*;

    int unsigned healthy;
    int unsigned step;
    int unsigned rank;

    always_comb begin
        healthy = unsigned'($countones(~fault_i));
        step    = spacing(PERIOD, N_CELLS, healthy);
        rank    = 0;
        for (int j = 0; j < N_CELLS; j++) begin
            off_o[j] = '0;
            if (!fault_i[j]) begin
                off_o[j] = CNT_W'(rank * step);
                rank     = rank + 1;
            end
        end
    end
endmodule

// File: rtl/sc_pwm_cell.sv
module sc_pwm_cell #(
    parameter int PERIOD = 5000,
    parameter int CNT_W  = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] off_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic             en_i,
    output logic             gate_a_o,
    output logic             gate_b_o
);
    import sc_pwm_pkg::*;

    typedef struct packed {
        logic a;
        logic b;
    } gates_t;

    gates_t      gt_d, gt_q;
    int unsigned ph_a, ph_b;

    always_comb begin
        ph_a   = phase_of(32'(cnt_i), 32'(off_i), PERIOD);
        ph_b   = shift_half(ph_a, PERIOD);
        gt_d.a = en_i && (ph_a < 32'(duty_i));
        gt_d.b = en_i && (ph_b < 32'(duty_i));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gt_q <= '0;
        else        gt_q <= gt_d;
    end

    assign gate_a_o = gt_q.a;
    assign gate_b_o = gt_q.b;

    AST_FAILED_CELL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!gt_q.a && !gt_q.b)); // R7
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(gt_q.a && gt_q.b)); // R8
endmodule

// File: rtl/sc_interleave_pwm.sv
module sc_interleave_pwm #(
    parameter int N_CELLS = 4,
    parameter int PERIOD  = 5000,
    localparam int CNT_W  = $clog2(PERIOD)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sync_i,
    input  logic [N_CELLS*CNT_W-1:0]   duty_i,
    input  logic [N_CELLS-1:0]         fault_i,
    output logic [2*N_CELLS-1:0]       gate_o
);
    localparam int HALF = PERIOD / 2;
    localparam logic [CNT_W-1:0] DMAX = CNT_W'(HALF - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    typedef struct packed {
        logic [CNT_W-1:0]                cnt;
        logic [N_CELLS-1:0][CNT_W-1:0]   duty;
        logic [N_CELLS-1:0]              fault;
        logic [N_CELLS-1:0][CNT_W-1:0]   off;
    } state_t;

    state_t st_d, st_q;
    logic [N_CELLS-1:0][CNT_W-1:0] plan_off;
    logic boundary;

    sc_pwm_plan #(.N_CELLS(N_CELLS), .PERIOD(PERIOD), .CNT_W(CNT_W)) u_plan (
        .fault_i (fault_i),
        .off_o   (plan_off)
    );

    always_comb begin
        st_d     = st_q;
        boundary = sync_i || (st_q.cnt == LAST);
        if (boundary) begin
            st_d.cnt   = '0;
            st_d.fault = fault_i;
            st_d.off   = plan_off;
            for (int j = 0; j < N_CELLS; j++) begin
                st_d.duty[j] = (duty_i[j*CNT_W +: CNT_W] > DMAX) ? DMAX
                                                                 : duty_i[j*CNT_W +: CNT_W];
            end
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar j = 0; j < N_CELLS; j++) begin : g_cell
        sc_pwm_cell #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt_i    (st_q.cnt),
            .off_i    (st_q.off[j]),
            .duty_i   (st_q.duty[j]),
            .en_i     (!st_q.fault[j]),
            .gate_a_o (gate_o[2*j]),
            .gate_b_o (gate_o[2*j+1])
        );

        AST_DUTY_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.duty[j] <= DMAX); // R4
        AST_OFFSET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            !st_q.fault[j] |-> (st_q.off[j] < CNT_W'(HALF))); // R6
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST); // R2
    AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> (st_q.cnt == '0)); // R2
    AST_PLAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_i && st_q.cnt != LAST) |=> ($stable(st_q.fault) && $stable(st_q.duty))); // R3
endmodule

// File: tb/sim_sc_interleave_pwm.sv
`timescale 1ns/1ps
module sim_sc_interleave_pwm;
    localparam int N = 4;
    localparam int P = 40;
    localparam int H = P / 2;
    localparam int W = $clog2(P);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_i = 1'b0;
    logic [N*W-1:0] duty_i = '0;
    logic [N-1:0] fault_i = '0;
    logic [2*N-1:0] gate_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    int mcnt;
    int mduty [N];
    logic [N-1:0] mfault;

    always #2 clk = ~clk;

    sc_interleave_pwm #(.N_CELLS(N), .PERIOD(P)) u0 (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_i),
        .duty_i(duty_i), .fault_i(fault_i), .gate_o(gate_o)
    );

    function automatic logic [2*N-1:0] exp_gates();
        logic [2*N-1:0] g;
        int m, step, r, off, pa, pb;
        g = '0;
        m = 0;
        for (int j = 0; j < N; j++) if (!mfault[j]) m++;
        step = (m > 0) ? P / (2 * m) : 0;
        r = 0;
        for (int j = 0; j < N; j++) begin
            if (!mfault[j]) begin
                off = r * step;
                r++;
                pa = (mcnt - off + P) % P;
                pb = (pa + H) % P;
                g[2*j]   = (pa < mduty[j]);
                g[2*j+1] = (pb < mduty[j]);
            end
        end
        return g;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [2*N-1:0] got,
                         input logic [2*N-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic set_duty(input int d0, input int d1, input int d2, input int d3);
        duty_i = {W'(d3), W'(d2), W'(d1), W'(d0)};
    endtask

    // One clock: predict, advance, compare at the falling edge.
    task automatic cyc(input bit s, input string tag);
        logic [2*N-1:0] e;
        bit bnd;
        e = exp_gates();
        sync_i = s;
        @(posedge clk);
        bnd = s || (mcnt == P - 1);
        if (bnd) begin
            mcnt = 0;
            for (int j = 0; j < N; j++) begin
                mduty[j] = int'(duty_i[j*W +: W]);
                if (mduty[j] > H - 1) mduty[j] = H - 1;
            end
            mfault = fault_i;
        end else begin
            mcnt++;
        end
        @(negedge clk);
        sync_i = 1'b0;
        check(gate_o === e, tag, gate_o, e);
        for (int j = 0; j < N; j++)
            if (gate_o[2*j] && gate_o[2*j+1]) check(1'b0, "R8", gate_o, e);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, tag);
    endtask

    task automatic to_last();
        while (mcnt != P - 1) cyc(1'b0, "R5");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        mcnt = 0;
        mfault = '0;
        for (int j = 0; j < N; j++) mduty[j] = 0;

        // R1: reset state
        set_duty(10, 10, 10, 10);
        repeat (3) @(negedge clk);
        check(gate_o === '0, "R1", gate_o, '0);
        rst_n = 1'b1;
        cyc(1'b0, "R1");

        // R5: all healthy, directed duties
        to_last();
        set_duty(10, 5, 19, 0);
        run(2 * P, "R5");

        // R4: commands above the limit
        to_last();
        set_duty(63, 20, 25, 40);
        run(P, "R4");
        check(gate_o[0] === 1'b0, "R4", gate_o, '0);

        // R6: slave fails, then master fails, then three fail
        set_duty(12, 12, 12, 12);
        to_last();
        fault_i = 4'b0010;
        run(P, "R6");
        to_last();
        fault_i = 4'b0011;
        run(P, "R6");
        to_last();
        fault_i = 4'b0111;
        run(P, "R6");

        // R7: every cell failed
        to_last();
        fault_i = 4'b1111;
        run(P, "R7");
        check(gate_o === '0, "R7", gate_o, '0);

        // R3: changes mid-period and one cycle around the boundary
        to_last();
        fault_i = 4'b0000;
        set_duty(8, 8, 8, 8);
        run(15, "R3");
        fault_i = 4'b0100;
        set_duty(18, 3, 18, 3);
        run(P - 16, "R3");
        fault_i = 4'b1000;
        cyc(1'b0, "R3");
        fault_i = 4'b0001;
        run(P, "R3");

        // R2: early restart strobe, and strobe at the wrap cycle
        set_duty(15, 15, 15, 15);
        run(12, "R2");
        fault_i = 4'b0000;
        cyc(1'b1, "R2");
        run(P / 2, "R2");
        to_last();
        fault_i = 4'b0110;
        cyc(1'b1, "R2");
        run(P, "R2");

        // Random plans with occasional early strobes
        for (int k = 0; k < 40; k++) begin
            int len;
            fault_i = N'($urandom_range(0, (1 << N) - 1));
            set_duty($urandom_range(0, 63), $urandom_range(0, 25),
                     $urandom_range(0, 19), $urandom_range(0, 30));
            len = ($urandom_range(0, 3) == 0) ? $urandom_range(3, P - 2) : P;
            run(len, "R5");
            if (len != P) cyc(1'b1, "R2");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule